// File: doc/BRIEF.md
# Four-to-one serial transmit serializer

This block turns a stream of 4-bit parallel words into a single serial bit stream running four times faster. Upstream logic presents a word on `pdata_i` and strobes it with its own parallel clock `pclk_in_i`; the word is latched on the rising edge of that clock. A local divide-by-four of the serial clock is driven out on `pclk_o` so that upstream logic can time its words from it. Once per `pclk_o` period the latched word moves into a shift register clocked by the serial clock, and that register sends the bits out on `sdata_o`, most significant lane first.

The incoming parallel clock is loosely phase-locked to `pclk_o`. Its rising edge must land within a small window after the `pclk_o` rising edge. The block resamples `pclk_in_i` in the serial domain through a two-flop synchronizer. It compares the counter phase at which each edge arrives with the window bounds `WIN_LO`..`WIN_HI`, which are given in serial-clock cycles. An edge outside the window raises a sticky error flag. A skew of s cycles means that the parallel clock rises partway through counter phase s.

Top module: `ser4_tx`

## Requirements
- R1: `pdata_i` is latched only on a rising edge of `pclk_in_i`; changes to `pdata_i` at any other time do not affect the transmitted word.
- R2: `pclk_o` is the serial clock divided by four. It is high in counter phases 0 and 1 and low in phases 2 and 3. After reset is released, the k-th serial clock edge leaves the counter in phase k mod 4.
- R3: The shift register reloads from the input register at the serial clock edge that ends phase 3, which is the edge where `pclk_o` rises. For this to work, `WIN_HI` must be at most 2.
- R4: Bit 3 of a word is sent first and bit 0 last, one bit per serial cycle. The word latched during one `pclk_o` period is sent during the next one, and consecutive words follow with no gap.
- R5: While `rst_ni` is low, `pclk_o` is 1, `sdata_o` is 0 and `win_err_o` is 0. After reset, `sdata_o` stays 0 until the first latched word has been loaded.
- R6: A `pclk_in_i` rising edge inside counter phase s, with `WIN_LO` <= s <= `WIN_HI`, never sets `win_err_o`. The defaults are 0 and 2.
- R7: A `pclk_in_i` rising edge in any other phase sets `win_err_o` at the third serial edge after the edge occurs. The flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial shift clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pclk_in_i | input | 1 | Incoming parallel data clock |
| pdata_i | input | WIDTH | Parallel data word, lane 3 sent first |
| pclk_o | output | 1 | Divide-by-four parallel clock output |
| sdata_o | output | 1 | Serial data output |
| win_err_o | output | 1 | Sticky flag for a parallel clock edge outside the window |

## Verification
On every cycle, the assertions check the following:
- `pclk_o` changes only on its two phase boundaries.
- The shift register reload coincides with a `pclk_o` rising edge.
- A reload puts the top bit of the latched word on the output.
- A synchronized edge lasts one cycle.
- The error flag never clears on its own.

The bench sweeps every skew phase against words that cycle through all 16 values. Only these scenarios can show the following:
- The bit order and the one-period latency.
- That data changes between strobes are ignored.
- The exact cycle at which an out-of-window edge is flagged.
- That the flag is cleared by reset.

// File: rtl/ser4_pkg.sv
package ser4_pkg;
  localparam int unsigned SYNC_LAT = 2;

  function automatic logic phase_in_win(int unsigned off, int unsigned lo, int unsigned hi);
    return (off >= lo) && (off <= hi);
  endfunction
endpackage

// File: rtl/ser4_cap.sv
module ser4_cap #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             pclk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge pclk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/ser4_timing.sv
module ser4_timing #(
  parameter int unsigned WIDTH = 4,
  localparam int unsigned CW = $clog2(WIDTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [CW-1:0] cnt_o,
  output logic          load_o,
  output logic          pclk_o
);
  localparam logic [CW-1:0] LAST_PH = CW'(WIDTH - 1);
  localparam logic [CW-1:0] HALF_PH = CW'(WIDTH / 2 - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + CW'(1);
  end

  assign cnt_o  = cnt_q;
  assign load_o = (cnt_q == LAST_PH);
  assign pclk_o = ~cnt_q[CW-1];

  assert_pclk_edges_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != LAST_PH && cnt_q != HALF_PH) |=> $stable(pclk_o));
endmodule

// File: rtl/ser4_win.sv
module ser4_win #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned WIN_LO = 0,
  parameter int unsigned WIN_HI = 2,
  localparam int unsigned CW = $clog2(WIDTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pclk_async_i,
  input  logic [CW-1:0] cnt_i,
  output logic          err_o
);
  import ser4_pkg::*;

  logic [SYNC_LAT:0] sh_q;
  logic              rise;
  logic [CW-1:0]     off;
  logic              err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_LAT-1:0], pclk_async_i};
  end

  assign rise = sh_q[SYNC_LAT-1] & ~sh_q[SYNC_LAT];
  // phase at which the raw edge occurred, undoing synchronizer latency
  assign off  = cnt_i - CW'(SYNC_LAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else if (rise && !phase_in_win(int'(off), WIN_LO, WIN_HI)) err_q <= 1'b1;
  end

  assign err_o = err_q;

  assert_err_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
  assert_edge_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> !rise);
endmodule

// File: rtl/ser4_shift.sv
module ser4_shift #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] word_i,
  output logic             sdata_o
);
  logic [WIDTH-1:0] sreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sreg_q <= '0;
    else if (load_i) sreg_q <= word_i;
    else             sreg_q <= {sreg_q[WIDTH-2:0], 1'b0};
  end

  assign sdata_o = sreg_q[WIDTH-1];

  assert_load_msb_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (sdata_o == $past(word_i[WIDTH-1])));
endmodule

// File: rtl/ser4_tx.sv
module ser4_tx #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned WIN_LO = 0,
  parameter int unsigned WIN_HI = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pclk_in_i,
  input  logic [WIDTH-1:0] pdata_i,
  output logic             pclk_o,
  output logic             sdata_o,
  output logic             win_err_o
);
  localparam int unsigned CW = $clog2(WIDTH);

  logic [WIDTH-1:0] cap_q;
  logic [CW-1:0]    cnt;
  logic             load_en;

  ser4_cap #(.WIDTH(WIDTH)) u_cap (
    .pclk_i (pclk_in_i),
    .rst_ni (rst_ni),
    .d_i    (pdata_i),
    .q_o    (cap_q)
  );

  ser4_timing #(.WIDTH(WIDTH)) u_tim (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_o  (cnt),
    .load_o (load_en),
    .pclk_o (pclk_o)
  );

  ser4_win #(.WIDTH(WIDTH), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_win (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pclk_async_i (pclk_in_i),
    .cnt_i        (cnt),
    .err_o        (win_err_o)
  );

  ser4_shift #(.WIDTH(WIDTH)) u_shf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_en),
    .word_i  (cap_q),
    .sdata_o (sdata_o)
  );

  assert_load_at_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_en |=> $rose(pclk_o));
endmodule

// File: tb/sim_ser4_tx.sv
`timescale 1ns/1ps
module sim_ser4_tx;
  localparam int WIDTH  = 4;
  localparam int WIN_HI = 2;
  localparam real TCLK  = 5.0;

  logic clk = 1'b0;
  logic rst_ni;
  logic pclk_in;
  logic [WIDTH-1:0] pdata;
  logic pclk_o, sdata_o, win_err_o;

  int checks = 0;
  int fails  = 0;

  always #(TCLK/2) clk = ~clk;

  ser4_tx #(.WIDTH(WIDTH), .WIN_LO(0), .WIN_HI(WIN_HI)) u0 (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .pclk_in_i (pclk_in),
    .pdata_i   (pdata),
    .pclk_o    (pclk_o),
    .sdata_o   (sdata_o),
    .win_err_o (win_err_o)
  );

  function automatic logic [3:0] word_of(int k, int s);
    return 4'((k + 5 * s) & 15);
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic run_scen(input int s, input int nper);
    rst_ni  = 1'b0;
    pclk_in = 1'b0;
    pdata   = '0;
    repeat (2) @(posedge clk);
    #1;
    chk(pclk_o == 1'b1, "R5 reset pclk_o", int'(pclk_o), 1);
    chk(sdata_o == 1'b0, "R5 reset sdata_o", int'(sdata_o), 0);
    chk(win_err_o == 1'b0, "R5 R7 reset clears err", int'(win_err_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    for (int n = 1; n <= nper * 4; n++) begin
      int k, ph, expb;
      @(posedge clk);
      #1;
      k  = n / 4;
      ph = n % 4;
      chk(pclk_o == (ph < 2), "R2 pclk_o phase", int'(pclk_o), int'(ph < 2));
      if (s <= WIN_HI) begin
        if (k >= 2) begin
          expb = int'(word_of(k - 1, s) >> (3 - ph)) & 1;
          chk(int'(sdata_o) == expb, "R1/R3/R4 serial bit", int'(sdata_o), expb);
        end else begin
          chk(sdata_o == 1'b0, "R5 startup zeros", int'(sdata_o), 0);
        end
        chk(win_err_o == 1'b0, "R6 in-window edge", int'(win_err_o), 0);
      end else begin
        if (n == 9)  chk(win_err_o == 1'b0, "R7 flag not early", int'(win_err_o), 0);
        if (n >= 10) chk(win_err_o == 1'b1, "R7 flag set and sticky", int'(win_err_o), 1);
      end
      if (ph == 0 && k >= 1) pdata = word_of(k, s);
      #1.5;
      if (k >= 1 && ph == s) pclk_in = 1'b1;
      if (ph == ((s + 2) % 4)) pclk_in = 1'b0;
      if (s < 3 && ph == s + 1 && k >= 1) pdata = ~pdata; // R1: change between strobes
    end
  endtask

  initial begin
    rst_ni  = 1'b0;
    pclk_in = 1'b0;
    pdata   = '0;
    for (int s = 0; s < 4; s++) run_scen(s, 20);
    run_scen(0, 6);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(TCLK * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule